// File: doc/BRIEF.md
# Low-Power Wake-Up Interval Timer

This block is an 8-bit up-counter that raises a sticky overflow flag, and from it an interrupt request, each time the count wraps from its top value back to zero. The wrap is meant as a periodic wake-up event. Each count step comes from a 15-stage binary prescaler. A 4-bit select picks the divide ratio. The prescaler input is either the system clock itself or a slow external timer clock.

The external clock can be used in two ways. In the oversampled mode, the system clock samples the external input, and each detected rising edge is one prescaler event. The count then stays readable with the system clock. In the direct mode, the external clock drives a second counting engine, so counting goes on while the system clock is stopped. That engine takes its enable, its divide select and any count reload through two-flop synchronisers. Its overflow returns to the system domain as a toggle with a fixed latency. The CPU side is a small register port with a combinational read and a single-cycle write strobe. There is no data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `rtt_wake_timer`

## Requirements
- R1: Address 0 holds the 8-bit count. A write stores the value, and a read returns the count of the engine that is active.
- R2: When a count step takes the count from 0xFF to 0x00, the flag (address 1, bit 2) is set. In the system-clock modes it is set on the same edge as the wrap.
- R3: `irq` is 1 exactly when the flag, the interrupt enable (address 1, bit 1) and the timer enable (address 1, bit 0) are all 1.
- R4: The flag is sticky. Only a write to address 1 with bit 2 = 0 clears it, and a write with bit 2 = 1 leaves it unchanged. A flag left set makes `irq` assert again as soon as both enables are 1.
- R5: The divide select sits at address 2, bits 3:0. A value of 0 gives one count step per event. A value n from 1 to 15 gives one step per 2^n events. A write to the count clears the prescaler.
- R6: While the timer enable is 0, the count and the prescaler keep their values. A later re-enable continues the prescaler phase.
- R7: When address 1 bit 3 (oversample) = 1 and bit 4 (external source) = 1, each rising edge of `ext_clk` that the system clock sees is one prescaler event. Each level must last at least two system cycles.
- R8: When bit 4 = 0, every system-clock cycle is one prescaler event, whatever bit 3 is.
- R9: When bit 3 = 0 and bit 4 = 1 (direct mode), `ext_clk` clocks the counter. An enable change takes effect after two `ext_clk` rising edges. A count write is loaded on the third `ext_clk` rising edge after it. Counting continues while the system clock is stopped.
- R10: In direct mode, the flag is set on the third system-clock rising edge after the `ext_clk` edge that wraps the count.
- R11: Reset clears the count, both prescalers, the flag and every control field. Address 3 reads as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_sys | input | 1 | System clock, may be stopped |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| ext_clk | input | 1 | External timer clock |
| reg_wr | input | 1 | Register write strobe, one system cycle |
| reg_addr | input | 2 | Register address: 0 count, 1 control, 2 divide select |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Combinational read data for `reg_addr` |
| irq | output | 1 | Wake-up interrupt request |

## Verification
The checker watches the system-domain rules on every cycle. It checks that a wrap or a returned direct-mode overflow sets the flag. It checks that the flag survives every cycle that does not clear it. It checks that a write dropping the interrupt enable silences `irq`. It checks that a disabled counter never moves, and that every prescaler tick advances the count by one. The divide ratios, the continuation of the prescaler phase across a disable, edge counting of the external input, direct-mode counting with the system clock stopped, the synchroniser latencies and the clear-then-re-enable order are shown only by the bench's sweeps and scenarios.

// File: rtl/rtt_pkg.sv
package rtt_pkg;
  localparam int CNT_W  = 8;
  localparam int PRE_W  = 15;
  localparam int SEL_W  = 4;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    A_COUNT = 2'd0,
    A_CTRL  = 2'd1,
    A_PSEL  = 2'd2,
    A_NONE  = 2'd3
  } rtt_addr_e;

  // control register bit positions
  localparam int B_EN   = 0;
  localparam int B_IE   = 1;
  localparam int B_FLAG = 2;
  localparam int B_OVS  = 3;
  localparam int B_SRC  = 4;

  typedef struct packed {
    logic src_ext;
    logic ovs;
    logic ie;
    logic en;
  } rtt_ctrl_t;
endpackage

// File: rtl/rtt_sync.sv
module rtt_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/rtt_prescaler.sv
module rtt_prescaler #(
  parameter int PRE_W = 15,
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             adv,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] mask;

  // low `sel` bits must all be one for the carry out of the chosen tap
  always_comb begin
    mask = '0;
    for (int i = 0; i < PRE_W; i++) begin
      if (i < int'(sel)) mask[i] = 1'b1;
    end
  end

  assign tick = adv & ((pre_q & mask) == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pre_q <= '0;
    else if (clr) pre_q <= '0;
    else if (adv) pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/rtt_counter.sv
module rtt_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             step,
  output logic [CNT_W-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (load) cnt <= load_val;
    else if (step) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/rtt_tick_engine.sv
module rtt_tick_engine #(
  parameter int CNT_W = 8,
  parameter int PRE_W = 15,
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             run,
  input  logic             evt,
  input  logic [SEL_W-1:0] sel,
  output logic [CNT_W-1:0] cnt,
  output logic             tick
);
  logic adv;
  assign adv = run & evt & ~load;

  rtt_prescaler #(.PRE_W(PRE_W), .SEL_W(SEL_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .clr(load), .adv(adv), .sel(sel), .tick(tick)
  );

  rtt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val),
    .step(tick), .cnt(cnt)
  );
endmodule

// File: rtl/rtt_wake_timer.sv
module rtt_wake_timer
  import rtt_pkg::*;
#(
  parameter int CNT_W       = rtt_pkg::CNT_W,
  parameter int PRE_W       = rtt_pkg::PRE_W,
  parameter int SEL_W       = rtt_pkg::SEL_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_sys,
  input  logic              rst_n,
  input  logic              ext_clk,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [CNT_W-1:0]  reg_wdata,
  output logic [CNT_W-1:0]  reg_rdata,
  output logic              irq
);
  localparam int XW = SEL_W + 2;   // run, select, load toggle

  // ---------------- system-clock register side ----------------
  rtt_ctrl_t        ctrl_q;
  logic             flag_q;
  logic [SEL_W-1:0] psel_q;
  logic             ld_tgl_q;
  logic [CNT_W-1:0] ld_val_q;

  logic wr_count, wr_ctrl, wr_psel;
  assign wr_count = reg_wr & (reg_addr == A_COUNT);
  assign wr_ctrl  = reg_wr & (reg_addr == A_CTRL);
  assign wr_psel  = reg_wr & (reg_addr == A_PSEL);

  logic direct;
  assign direct = ctrl_q.src_ext & ~ctrl_q.ovs;

  // oversampling of the external input
  logic ext_s, ext_d, ext_rise;
  rtt_sync #(.W(1), .STAGES(SYNC_STAGES)) u_ext_smp (
    .clk(clk_sys), .rst_n(rst_n), .d(ext_clk), .q(ext_s)
  );
  always_ff @(posedge clk_sys or negedge rst_n) begin
    if (!rst_n) ext_d <= 1'b0;
    else        ext_d <= ext_s;
  end
  assign ext_rise = ext_s & ~ext_d;

  // system-domain engine (oscillator source or oversampled external)
  logic [CNT_W-1:0] cnt_s;
  logic             tick_s, run_s, evt_s, wrap_s;
  assign run_s  = ctrl_q.en & ~direct;
  assign evt_s  = ctrl_q.src_ext ? ext_rise : 1'b1;

  rtt_tick_engine #(.CNT_W(CNT_W), .PRE_W(PRE_W), .SEL_W(SEL_W)) u_sys_eng (
    .clk(clk_sys), .rst_n(rst_n), .load(wr_count), .load_val(reg_wdata),
    .run(run_s), .evt(evt_s), .sel(psel_q), .cnt(cnt_s), .tick(tick_s)
  );
  assign wrap_s = tick_s & (cnt_s == {CNT_W{1'b1}});

  // ---------------- external-clock domain ----------------
  logic [XW-1:0]    to_x_d, to_x_q;
  logic             run_x, ld_tgl_x, ld_seen_x, load_x, tick_x, ovf_tgl_x;
  logic [SEL_W-1:0] psel_x;
  logic [CNT_W-1:0] cnt_x;

  assign to_x_d = {ctrl_q.en & direct, psel_q, ld_tgl_q};
  rtt_sync #(.W(XW), .STAGES(SYNC_STAGES)) u_to_ext (
    .clk(ext_clk), .rst_n(rst_n), .d(to_x_d), .q(to_x_q)
  );
  assign {run_x, psel_x, ld_tgl_x} = to_x_q;
  assign load_x = ld_tgl_x ^ ld_seen_x;

  rtt_tick_engine #(.CNT_W(CNT_W), .PRE_W(PRE_W), .SEL_W(SEL_W)) u_ext_eng (
    .clk(ext_clk), .rst_n(rst_n), .load(load_x), .load_val(ld_val_q),
    .run(run_x), .evt(1'b1), .sel(psel_x), .cnt(cnt_x), .tick(tick_x)
  );

  always_ff @(posedge ext_clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_seen_x <= 1'b0;
      ovf_tgl_x <= 1'b0;
    end else begin
      ld_seen_x <= ld_tgl_x;
      if (tick_x && (cnt_x == {CNT_W{1'b1}})) ovf_tgl_x <= ~ovf_tgl_x;
    end
  end

  // overflow toggle back into the system domain
  logic ovf_s, ovf_seen, dir_ovf;
  rtt_sync #(.W(1), .STAGES(SYNC_STAGES)) u_ovf_back (
    .clk(clk_sys), .rst_n(rst_n), .d(ovf_tgl_x), .q(ovf_s)
  );
  assign dir_ovf = ovf_s ^ ovf_seen;

  // ---------------- register state ----------------
  always_ff @(posedge clk_sys or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      flag_q   <= 1'b0;
      psel_q   <= '0;
      ld_tgl_q <= 1'b0;
      ld_val_q <= '0;
      ovf_seen <= 1'b0;
    end else begin
      ovf_seen <= ovf_s;
      if (wr_ctrl) begin
        ctrl_q.en      <= reg_wdata[B_EN];
        ctrl_q.ie      <= reg_wdata[B_IE];
        ctrl_q.ovs     <= reg_wdata[B_OVS];
        ctrl_q.src_ext <= reg_wdata[B_SRC];
      end
      if (wr_psel) psel_q <= reg_wdata[SEL_W-1:0];
      if (wr_count) begin
        ld_val_q <= reg_wdata;
        ld_tgl_q <= ~ld_tgl_q;
      end
      // a new overflow wins over a clear in the same cycle
      flag_q <= wrap_s | dir_ovf | (flag_q & ~(wr_ctrl & ~reg_wdata[B_FLAG]));
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      A_COUNT: reg_rdata = direct ? cnt_x : cnt_s;
      A_CTRL: begin
        reg_rdata[B_EN]   = ctrl_q.en;
        reg_rdata[B_IE]   = ctrl_q.ie;
        reg_rdata[B_FLAG] = flag_q;
        reg_rdata[B_OVS]  = ctrl_q.ovs;
        reg_rdata[B_SRC]  = ctrl_q.src_ext;
      end
      A_PSEL:  reg_rdata[SEL_W-1:0] = psel_q;
      default: reg_rdata = '0;
    endcase
  end

  assign irq = flag_q & ctrl_q.ie & ctrl_q.en;
endmodule

// File: rtl/rtt_wake_timer_chk.sv
module rtt_wake_timer_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk_sys,
  input logic             rst_n,
  input logic             irq,
  input logic             wr_ctrl,
  input logic             wr_count,
  input logic             w_flag,
  input logic             w_ie,
  input logic             flag_q,
  input logic             en_q,
  input logic             wrap_s,
  input logic             dir_ovf,
  input logic             tick_s,
  input logic [CNT_W-1:0] cnt_s
);
  p_flag_on_wrap_r2: assert property (@(posedge clk_sys) disable iff (!rst_n)
    wrap_s |=> flag_q);

  p_flag_on_direct_r10: assert property (@(posedge clk_sys) disable iff (!rst_n)
    dir_ovf |=> flag_q);

  p_flag_sticky_r4: assert property (@(posedge clk_sys) disable iff (!rst_n)
    (flag_q && !(wr_ctrl && !w_flag)) |=> flag_q);

  p_irq_drop_r3: assert property (@(posedge clk_sys) disable iff (!rst_n)
    (wr_ctrl && !w_ie) |=> !irq);

  p_hold_disabled_r6: assert property (@(posedge clk_sys) disable iff (!rst_n)
    (!en_q && !wr_count) |=> $stable(cnt_s));

  p_tick_steps_r5: assert property (@(posedge clk_sys) disable iff (!rst_n)
    (tick_s && !wr_count) |=> (cnt_s == CNT_W'($past(cnt_s) + 1'b1)));
endmodule

bind rtt_wake_timer rtt_wake_timer_chk #(.CNT_W(CNT_W)) u_rtt_chk (
  .clk_sys(clk_sys), .rst_n(rst_n), .irq(irq),
  .wr_ctrl(wr_ctrl), .wr_count(wr_count),
  .w_flag(reg_wdata[rtt_pkg::B_FLAG]), .w_ie(reg_wdata[rtt_pkg::B_IE]),
  .flag_q(flag_q), .en_q(ctrl_q.en), .wrap_s(wrap_s), .dir_ovf(dir_ovf),
  .tick_s(tick_s), .cnt_s(cnt_s)
);

// File: tb/test_rtt_wake_timer.sv
`timescale 1ns/1ps
module test_rtt_wake_timer;
  logic       clk = 1'b0;
  logic       sys_run = 1'b1;
  logic       rst_n = 1'b0;
  logic       ext_clk = 1'b0;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       irq;

  int checks = 0;
  int fails  = 0;
  logic [7:0] v;

  // 250 MHz system clock that the bench can stop
  initial forever begin
    #2;
    if (sys_run) clk = ~clk;
  end

  rtt_wake_timer i_rtt_wake_timer (
    .clk_sys(clk), .rst_n(rst_n), .ext_clk(ext_clk), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // time-based pulses: 8 ns high, 8 ns low
  task automatic ext_pulses(input int n);
    repeat (n) begin
      ext_clk = 1'b1; #8;
      ext_clk = 1'b0; #8;
    end
  endtask

  initial begin
    #600000;
    fails++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R11 reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v); chk("R11 reset read", v, 0);
    end
    chk("R11 reset irq", irq, 0);

    // R1 count read/write
    wr(0, 8'hA5); rd(0, v); chk("R1 count rw", v, 8'hA5);
    wr(0, 8'h5A); rd(0, v); chk("R1 count rw", v, 8'h5A);
    wr(2, 8'h0B); rd(2, v); chk("R5 psel rw", v, 8'h0B);
    rd(3, v); chk("R11 unmapped", v, 0);

    // R8 / R5 / R2: oscillator source sweep, k = j + 2 events
    for (int n = 0; n < 6; n++) begin
      for (int t = 0; t < 4; t++) begin
        int j, k, sum;
        j = (t == 0) ? 1 : (t == 1) ? 6 : (t == 2) ? 29 : 61;
        k = j + 2;
        sum = 8'hF0 + (k >> n);
        wr(2, 8'(n));
        wr(0, 8'hF0);
        wr(1, 8'h00);
        wr(1, 8'h01);
        idle(j);
        wr(1, 8'h04);
        rd(0, v); chk("R8 R5 osc count", v, sum & 8'hFF);
        rd(1, v); chk("R2 wrap flag", v, (sum > 255) ? 8'h04 : 8'h00);
      end
    end
    // R6 hold after disable
    rd(0, v);
    idle(20);
    begin
      logic [7:0] v2;
      rd(0, v2); chk("R6 hold count", v2, v);
    end

    // R5 count write clears prescaler
    wr(2, 8'd2); wr(0, 8'h10); wr(1, 8'h00);
    wr(1, 8'h01); idle(1); wr(1, 8'h04);
    rd(0, v); chk("R5 three events no tick", v, 8'h10);
    wr(0, 8'h20);
    wr(1, 8'h01); wr(1, 8'h04);
    rd(0, v); chk("R5 prescaler cleared by write", v, 8'h20);

    // R6 prescaler phase kept over disable
    wr(0, 8'h30); wr(1, 8'h00);
    wr(1, 8'h01); wr(1, 8'h04);
    idle(10);
    wr(1, 8'h01); wr(1, 8'h04);
    rd(0, v); chk("R6 prescaler phase kept", v, 8'h31);

    // R3 / R4 interrupt gating and clear order
    wr(2, 8'd0); wr(0, 8'hFD); wr(1, 8'h00);
    wr(1, 8'h03); idle(1); wr(1, 8'h06);
    rd(0, v); chk("R2 wrap to zero", v, 8'h00);
    chk("R3 irq off when disabled", irq, 0);
    wr(1, 8'h07); chk("R3 irq all set", irq, 1);
    wr(1, 8'h05); chk("R3 irq off ie clear", irq, 0);
    rd(1, v); chk("R4 flag kept", v[2], 1);
    wr(1, 8'h07); chk("R4 pending re-asserts", irq, 1);
    wr(1, 8'h05); wr(1, 8'h01);
    rd(1, v); chk("R4 flag cleared", v[2], 0);
    wr(1, 8'h03); chk("R4 no irq after clear", irq, 0);
    wr(1, 8'h00);

    // R7 oversampled external edges
    for (int n = 0; n < 4; n++) begin
      wr(2, 8'(n)); wr(0, 8'h40);
      wr(1, 8'h18); wr(1, 8'h19);
      ext_pulses(8);
      idle(4);
      wr(1, 8'h1C);
      rd(0, v); chk("R7 oversampled edges", v, 8'h40 + (8 >> n));
    end

    // R9 direct mode
    wr(1, 8'h10); wr(2, 8'd0); wr(0, 8'h70);
    ext_pulses(3);
    rd(0, v); chk("R9 direct load", v, 8'h70);
    wr(1, 8'h11);
    ext_pulses(7);
    rd(0, v); chk("R9 direct count", v, 8'h75);
    @(negedge clk); sys_run = 1'b0;
    ext_pulses(10);
    rd(0, v); chk("R9 count with sys clock stopped", v, 8'h7F);
    sys_run = 1'b1;
    idle(2);
    wr(1, 8'h10); wr(2, 8'd1); wr(0, 8'h00);
    ext_pulses(3);
    rd(0, v); chk("R9 reload after disable", v, 8'h00);
    wr(1, 8'h11);
    ext_pulses(10);
    rd(0, v); chk("R5 direct divide by 2", v, 8'h04);

    // R10 direct overflow latency
    wr(1, 8'h10); wr(2, 8'd0); wr(0, 8'hFE);
    ext_pulses(3);
    wr(1, 8'h13);
    ext_pulses(3);
    rd(0, v); chk("R9 at FF", v, 8'hFF);
    rd(1, v); chk("R10 flag before wrap", v[2], 0);
    ext_clk = 1'b1;
    @(posedge clk); @(posedge clk); #1;
    chk("R10 flag not yet", reg_rdata[2], 0);
    chk("R10 irq not yet", irq, 0);
    @(posedge clk); #1;
    chk("R10 flag at third edge", reg_rdata[2], 1);
    chk("R3 irq direct", irq, 1);
    @(negedge clk); ext_clk = 1'b0;
    rd(0, v); chk("R2 direct wrap", v, 8'h00);
    wr(1, 8'h11); chk("R3 irq cleared", irq, 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule